// File: doc/BRIEF.md
# Reconfigurable LFSR Keystream Cipher

This block produces a keystream from several linear feedback shift registers running side by side. Each register has its own programmable tap mask, so the feedback polynomial is not fixed in the gates. The mask is chosen at seed time: a few seed bits index a constant table of polynomials, and the rest of the seed fills the shift registers. Each enabled clock then emits one keystream bit and one ciphertext bit, which is the message bit XORed with that keystream bit.

A load strobe captures a new seed. In that same cycle it looks up the polynomials and writes both the tap masks and the shift states. Stepping starts on the next cycle in which the enable is high. The keystream bit is the XOR of the top stage of every lane. The block never steers itself away from the all-zero state. A lane seeded with zero stays at zero.

Top module: `rls_stream_cipher`

## Requirements
- R1: After reset, `ks_o`, `ct_o` and `valid_o` are 0. Every lane's shift state is zero and its tap mask is 0x01, so enabled steps before the first load give keystream 0.
- R2: The seed is split by field. `seed_i[1:0]` is the table index. Lane i takes its shift state from `seed_i[2+8*i +: 8]`, and bit j of that field becomes stage j+1.
- R3: The table holds the entries 0x81, 0x1D, 0x2B and 0x8E at indices 0 to 3. Lane i loads entry (index + i) mod 4 as its tap mask, and bit j of the mask enables stage j+1.
- R4: Stage 1 of every tap mask is forced to 1 whatever the table entry holds. For example, entry 0x8E loads as 0x8F.
- R5: On a step, every stage j takes the old value of stage j+1. Stage n takes the parity of (mask AND state).
- R6: On a step, `ks_o` takes the XOR of the stage-n bits of all lanes before the shift, and `ct_o` takes `msg_i` XOR that bit. `valid_o` is 1 in the following cycle.
- R7: Load has priority over enable. A load cycle does not step, it drives `valid_o` to 0 in the following cycle, and it leaves `ks_o` and `ct_o` unchanged. The next enabled cycle steps from the loaded state.
- R8: With enable and load both low, the states do not change, `valid_o` goes to 0, and `ks_o` and `ct_o` hold.
- R9: A lane whose shift state is all zero stays all zero while it steps.
- R10: With tap mask 0x81 and only stage 1 set, a lane reaches all ones after n = 8 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Seed capture and polynomial lookup strobe |
| seed_i | input | 26 | Seed: table index plus lane initial states |
| en_i | input | 1 | Step enable |
| msg_i | input | 1 | Message bit |
| ks_o | output | 1 | Registered keystream bit |
| ct_o | output | 1 | Registered ciphertext bit |
| valid_o | output | 1 | High the cycle after a step |

## Verification
The bench aims at the table index wrap. A lane offset applied without the modulo, or applied in the wrong direction, would load the wrong mask into lanes 1 and 2, and the keystream would diverge within a few steps. The bench seeds index 3 on purpose: that entry lacks stage 1, so a design that does not force the stage-1 tap would lose invertibility and produce a different stream. The bench raises load and enable in the same cycle to catch a design that steps on a load. It also leaves enable-low gaps to catch a design that keeps shifting or keeps reporting valid data. The single-bit seed with mask 0x81 checks the exact order of the ones filling in, so a reversed shift direction or a wrong tap position shows up on the keystream output.

// File: rtl/rls_pkg.sv
package rls_pkg;
  localparam int DefLanes  = 3;
  localparam int DefWidth  = 8;
  localparam int DefAddrW  = 2;
  localparam logic [31:0] DefPolyTable = 32'h8E2B1D81;  // entry e at [8e +: 8]
endpackage

// File: rtl/rls_poly_rom.sv
module rls_poly_rom #(
  parameter int NUM_LFSR = 3,
  parameter int LFSR_W   = 8,
  parameter int ADDR_W   = 2,
  parameter logic [(1<<ADDR_W)*LFSR_W-1:0] POLY_TABLE = '0
) (
  input  logic [ADDR_W-1:0]          idx_i,
  output logic [NUM_LFSR*LFSR_W-1:0] cr_o
);
  for (genvar g = 0; g < NUM_LFSR; g++) begin : g_lane
    localparam logic [ADDR_W-1:0] Ofs = ADDR_W'(g % (1 << ADDR_W));
    logic [ADDR_W-1:0] sel;
    assign sel = idx_i + Ofs;
    // stage 1 tap forced so the step stays invertible
    assign cr_o[g*LFSR_W +: LFSR_W] = POLY_TABLE[sel*LFSR_W +: LFSR_W] | LFSR_W'(1);
  end
endmodule

// File: rtl/rls_lfsr_lane.sv
module rls_lfsr_lane #(
  parameter int LFSR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [LFSR_W-1:0] cr_load_i,
  input  logic [LFSR_W-1:0] sr_load_i,
  output logic [LFSR_W-1:0] sr_o,
  output logic [LFSR_W-1:0] cr_o
);
  logic [LFSR_W-1:0] sr_q, cr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
      cr_q <= LFSR_W'(1);
    end else if (load_i) begin
      sr_q <= sr_load_i;
      cr_q <= cr_load_i;
    end else if (step_i) begin
      sr_q <= {^(cr_q & sr_q), sr_q[LFSR_W-1:1]};
    end
  end

  assign sr_o = sr_q;
  assign cr_o = cr_q;
endmodule

// File: rtl/rls_combiner.sv
module rls_combiner #(
  parameter int NUM_LFSR = 3
) (
  input  logic [NUM_LFSR-1:0] msb_i,
  output logic                ks_o
);
  assign ks_o = ^msb_i;
endmodule

// File: rtl/rls_stream_cipher.sv
module rls_stream_cipher #(
  parameter int NUM_LFSR = rls_pkg::DefLanes,
  parameter int LFSR_W   = rls_pkg::DefWidth,
  parameter int ADDR_W   = rls_pkg::DefAddrW,
  parameter logic [(1<<ADDR_W)*LFSR_W-1:0] POLY_TABLE = rls_pkg::DefPolyTable,
  localparam int SEED_W = ADDR_W + NUM_LFSR*LFSR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SEED_W-1:0] seed_i,
  input  logic              en_i,
  input  logic              msg_i,
  output logic              ks_o,
  output logic              ct_o,
  output logic              valid_o
);
  localparam int StateW = NUM_LFSR*LFSR_W;

  logic [StateW-1:0]   cr_lookup;
  logic [StateW-1:0]   sr_all, cr_all;
  logic [NUM_LFSR-1:0] msb;
  logic                step, ks_nxt;
  logic                ks_q, ct_q, valid_q;

  assign step = en_i & ~load_i;

  rls_poly_rom #(
    .NUM_LFSR(NUM_LFSR), .LFSR_W(LFSR_W), .ADDR_W(ADDR_W), .POLY_TABLE(POLY_TABLE)
  ) rom_i (
    .idx_i(seed_i[ADDR_W-1:0]),
    .cr_o (cr_lookup)
  );

  for (genvar g = 0; g < NUM_LFSR; g++) begin : g_lane
    rls_lfsr_lane #(.LFSR_W(LFSR_W)) lane_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load_i),
      .step_i   (step),
      .cr_load_i(cr_lookup[g*LFSR_W +: LFSR_W]),
      .sr_load_i(seed_i[ADDR_W + g*LFSR_W +: LFSR_W]),
      .sr_o     (sr_all[g*LFSR_W +: LFSR_W]),
      .cr_o     (cr_all[g*LFSR_W +: LFSR_W])
    );
    assign msb[g] = sr_all[g*LFSR_W + LFSR_W - 1];
  end

  rls_combiner #(.NUM_LFSR(NUM_LFSR)) comb_i (
    .msb_i(msb),
    .ks_o (ks_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ks_q    <= 1'b0;
      ct_q    <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= step;
      if (step) begin
        ks_q <= ks_nxt;
        ct_q <= msg_i ^ ks_nxt;
      end
    end
  end

  assign ks_o    = ks_q;
  assign ct_o    = ct_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/rls_stream_cipher_chk.sv
module rls_stream_cipher_chk #(
  parameter int NUM_LFSR = 3,
  parameter int LFSR_W   = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       load_i,
  input logic                       en_i,
  input logic                       msg_i,
  input logic                       ks_o,
  input logic                       ct_o,
  input logic                       valid_o,
  input logic [NUM_LFSR*LFSR_W-1:0] sr_all,
  input logic [NUM_LFSR*LFSR_W-1:0] cr_all
);
  a_r7_load_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !valid_o);

  a_r6_step_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> valid_o);

  a_r6_cipher_mix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (ct_o == ($past(msg_i) ^ ks_o)));

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> ($stable(sr_all) && !valid_o && $stable(ks_o)));

  for (genvar g = 0; g < NUM_LFSR; g++) begin : g_lane
    a_r4_tap1_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cr_all[g*LFSR_W]);

    a_r5_shift_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !load_i) |=>
        (sr_all[g*LFSR_W +: LFSR_W-1] == $past(sr_all[g*LFSR_W+1 +: LFSR_W-1])));

    a_r9_zero_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sr_all[g*LFSR_W +: LFSR_W] == '0 && !load_i) |=> (sr_all[g*LFSR_W +: LFSR_W] == '0));
  end
endmodule

bind rls_stream_cipher rls_stream_cipher_chk #(.NUM_LFSR(NUM_LFSR), .LFSR_W(LFSR_W)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .load_i (load_i),
  .en_i   (en_i),
  .msg_i  (msg_i),
  .ks_o   (ks_o),
  .ct_o   (ct_o),
  .valid_o(valid_o),
  .sr_all (sr_all),
  .cr_all (cr_all)
);

// File: tb/rls_stream_cipher_tb_top.sv
`timescale 1ns/1ps
module rls_stream_cipher_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [25:0] seed_i = '0;
  logic        en_i = 1'b0;
  logic        msg_i = 1'b0;
  logic        ks_o, ct_o, valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model: stage k of lane l at m_sr[l][k], k = 1..8
  bit m_sr [3][1:8];
  bit m_cr [3][1:8];
  bit e_ks, e_ct, e_valid;
  bit [7:0] tbl [4] = '{8'h81, 8'h1D, 8'h2B, 8'h8E};
  int ones_seen;
  int prbs = 32'h1ACE;

  always #4 clk_i = ~clk_i;

  rls_stream_cipher dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .seed_i(seed_i),
    .en_i(en_i), .msg_i(msg_i), .ks_o(ks_o), .ct_o(ct_o), .valid_o(valid_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void model_load(input bit [25:0] sd);
    int idx = int'(sd[1:0]);
    for (int l = 0; l < 3; l++) begin
      int e = (idx + l) % 4;
      for (int k = 1; k <= 8; k++) begin
        m_sr[l][k] = sd[2 + 8*l + k - 1];
        m_cr[l][k] = tbl[e][k-1];
      end
      m_cr[l][1] = 1'b1;
    end
  endfunction

  function automatic bit model_step();
    bit k_out = 0;
    for (int l = 0; l < 3; l++) begin
      bit fb = 0;
      k_out ^= m_sr[l][8];
      for (int k = 1; k <= 8; k++) fb ^= m_sr[l][k] & m_cr[l][k];
      for (int k = 1; k < 8; k++) m_sr[l][k] = m_sr[l][k+1];
      m_sr[l][8] = fb;
    end
    return k_out;
  endfunction

  task automatic cyc(input bit ld, input bit [25:0] sd, input bit e, input bit m, input string req);
    @(negedge clk_i);
    load_i = ld; seed_i = sd; en_i = e; msg_i = m;
    if (ld) begin
      model_load(sd);
      e_valid = 0;
    end else if (e) begin
      e_ks = model_step();
      e_ct = m ^ e_ks;
      e_valid = 1;
    end else begin
      e_valid = 0;
    end
    @(posedge clk_i);
    #1;
    chk(req, "ks_o", ks_o, e_ks);
    chk(req, "ct_o", ct_o, e_ct);
    chk(req, "valid_o", valid_o, e_valid);
  endtask

  function automatic bit next_msg();
    prbs = (prbs << 1) ^ (((prbs >> 31) & 1) != 0 ? 32'h04C11DB7 : 0);
    return prbs[7];
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < 3; l++)
      for (int k = 1; k <= 8; k++) begin
        m_sr[l][k] = 0;
        m_cr[l][k] = (k == 1);
      end
    e_ks = 0; e_ct = 0; e_valid = 0;
    #20;
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state at the ports
    chk("R1", "ks_o reset", ks_o, 0);
    chk("R1", "ct_o reset", ct_o, 0);
    chk("R1", "valid_o reset", valid_o, 0);
    // R1 and R9: zero state keeps keystream at 0
    for (int i = 0; i < 4; i++) cyc(0, '0, 1, next_msg(), "R1");

    // R10: mask 0x81, only stage 1 set in lane 0
    cyc(1, {8'h00, 8'h00, 8'h01, 2'd0}, 0, 0, "R7");
    ones_seen = 0;
    for (int s = 1; s <= 10; s++) begin
      cyc(0, '0, 1, 0, "R10");
      if (s >= 2 && s <= 9 && ks_o) ones_seen++;
      if (s == 1)  chk("R10", "first bit", ks_o, 0);
      if (s == 10) chk("R10", "bit after all-ones", ks_o, 0);
    end
    chk("R10", "ones during fill", ones_seen, 8);

    // R2, R3, R5, R6: index 1, mixed lane states
    cyc(1, {8'h7E, 8'h3C, 8'hA5, 2'd1}, 0, 0, "R2");
    for (int i = 0; i < 40; i++) cyc(0, '0, 1, next_msg(), "R3");

    // R7: load and enable together, then step from loaded state
    cyc(1, {8'h13, 8'hC9, 8'h5A, 2'd2}, 1, 1, "R7");
    chk("R7", "valid after load", valid_o, 0);
    for (int i = 0; i < 20; i++) cyc(0, '0, 1, next_msg(), "R6");

    // R8: idle gaps with toggling message
    for (int i = 0; i < 24; i++) cyc(0, '0, (i % 3) == 0, next_msg(), "R8");

    // R4: index 3 puts entry 0x8E (stage 1 clear) on lane 0
    cyc(1, {8'hE1, 8'h0F, 8'h96, 2'd3}, 0, 0, "R4");
    for (int i = 0; i < 40; i++) cyc(0, '0, 1, next_msg(), "R4");

    // R9: lane 1 zero, others running
    cyc(1, {8'h4D, 8'h00, 8'hB2, 2'd2}, 0, 0, "R9");
    for (int i = 0; i < 40; i++) cyc(0, '0, 1, next_msg(), "R9");

    // R5: long run to cover the full periods of the masks
    cyc(1, {8'h01, 8'h80, 8'hFF, 2'd0}, 0, 0, "R5");
    for (int i = 0; i < 300; i++) cyc(0, '0, 1, next_msg(), "R5");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule